// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block is an up/down counter core for a general-purpose timer whose count clock, start, stop and reinitialisation come from a selectable trigger. A 4-bit mode input chooses how the counter is driven: free running on the timer clock, one of three quadrature-encoder modes, reset on trigger, gated by trigger level, started by trigger, clocked by trigger edges, or reset-and-start on one trigger edge. A 3-bit select input picks the trigger from two timer inputs or the polarity-conditioned external input. A separate enable adds a second external-clock path that counts edges of the conditioned external input directly.

Every input pin is brought into the timer clock through a two-stage synchroniser, and edges are found against a registered copy of the synchronised level. The counter wraps at an auto-reload limit in both directions and pulses an update flag on every wrap and every trigger-driven reinitialisation. Software controls the counter-enable through set and clear pulses; trigger and combined modes set it from hardware.

Top module: `tmr_slave_ctl`

## Requirements
- R1: After a synchronous reset the count is 0, the counter-enable is 0, the direction output is 0 (up) and no update pulse is present.
- R2: With mode 0000, and with any mode code from 1001 to 1111, the counter advances by one per clock while the counter-enable is 1 and trigger edges have no effect.
- R3: Counting up from the auto-reload value gives 0, counting down from 0 gives the auto-reload value, and each such wrap raises the update output for exactly one cycle together with the new count.
- R4: Mode 0001 counts only on edges of input 2 and mode 0010 only on edges of input 1; a full forward quadrature cycle (in1,in2 = 00,10,11,01,00) adds 2 in either mode.
- R5: Mode 0011 counts on edges of both inputs (4 per quadrature cycle); the forward cycle counts up, the reverse cycle (00,01,11,10,00) counts down, and the direction output is 1 after a down step and 0 after an up step.
- R6: Mode 0100 clears the count to 0 and pulses update on a rising trigger edge, while otherwise counting on the clock.
- R7: Mode 0101 counts only while the trigger level is high; when the trigger is low the count holds and is not cleared.
- R8: Mode 0110 sets the counter-enable on a rising trigger edge without changing the count.
- R9: Mode 0111 advances the count by exactly one per rising edge of the selected trigger and ignores the other inputs.
- R10: Mode 1000, on one rising trigger edge, clears the count, pulses update and sets the counter-enable.
- R11: Trigger select 101 picks input 1, 110 picks input 2, 111 picks the conditioned external input; any other code selects no trigger, so trigger edges do nothing.
- R12: With the external-clock enable set, the count advances once per rising edge of the external input XOR the polarity bit (polarity 1 counts falling pin edges), and this source takes precedence over trigger edges in mode 0111.
- R13: With the external-clock enable set in mode 0101, external edges count only while the selected trigger level is high.
- R14: A pin change first affects the count on the third rising clock edge after it is applied, and a level held for many cycles produces a single count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Slave mode code |
| tsel_i | input | 3 | Trigger select code |
| ext_clk2_en_i | input | 1 | Enables counting on conditioned external edges |
| ext_pol_i | input | 1 | 1 inverts the external input |
| cen_set_i | input | 1 | Software pulse setting the counter-enable |
| cen_clr_i | input | 1 | Software pulse clearing the counter-enable |
| arr_i | input | CNT_W | Auto-reload limit |
| in1_i | input | 1 | Timer input 1 (quadrature A) |
| in2_i | input | 1 | Timer input 2 (quadrature B) |
| ext_i | input | 1 | External trigger pin |
| cnt_o | output | CNT_W | Counter value |
| dir_down_o | output | 1 | 1 when the last counted encoder step was downward |
| upd_o | output | 1 | One-cycle update pulse |
| cen_o | output | 1 | Counter-enable state |

## Verification
A wrong synchroniser or edge register shows up at the count as a missing, doubled or late step, visible three clock edges after a pin change. A wrong mode decode appears as a count that moves while it should hold (gated low, enable off, reserved trigger) or holds when it should move, within one cycle of the stimulus. A misplaced wrap limit or direction decision is seen as a wrong value or missing update pulse on the very step that crosses the auto-reload value or zero.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

    typedef enum logic [3:0] {
        SM_OFF    = 4'b0000,
        SM_ENC_B  = 4'b0001,
        SM_ENC_A  = 4'b0010,
        SM_ENC_AB = 4'b0011,
        SM_RESET  = 4'b0100,
        SM_GATED  = 4'b0101,
        SM_TRIG   = 4'b0110,
        SM_EXTCLK = 4'b0111,
        SM_COMBO  = 4'b1000
    } smode_e;

    typedef enum logic [1:0] {
        TS_NONE = 2'd0,
        TS_IN1  = 2'd1,
        TS_IN2  = 2'd2,
        TS_EXT  = 2'd3
    } tsrc_e;

    // index of each pin in the synchroniser bank
    localparam int PIN_IN1 = 0;
    localparam int PIN_IN2 = 1;
    localparam int PIN_EXT = 2;
    localparam int NUM_PINS = 3;

    typedef struct packed {
        logic tick;    // advance the counter one step
        logic down;    // step direction
        logic reinit;  // clear to zero with update
        logic start;   // set counter-enable
        logic enc;     // encoder mode active: direction output tracks steps
    } ctl_t;

    function automatic tsrc_e decode_tsel(input logic [2:0] code);
        case (code)
            3'b101:  return TS_IN1;
            3'b110:  return TS_IN2;
            3'b111:  return TS_EXT;
            default: return TS_NONE;
        endcase
    endfunction

    // returns {valid, down}; levels are the values after the edge
    function automatic logic [1:0] quad_eval(input logic a_chg, input logic b_chg,
                                             input logic a_lvl, input logic b_lvl,
                                             input logic use_a, input logic use_b);
        logic ea;
        logic eb;
        ea = a_chg & use_a;
        eb = b_chg & use_b;
        if (ea && eb)  return 2'b00;
        else if (ea)   return {1'b1, a_lvl == b_lvl};
        else if (eb)   return {1'b1, b_lvl != a_lvl};
        else           return 2'b00;
    endfunction

endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] chg_o
);
    localparam int MSB = STAGES - 1;

    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES-1:0] sh;
        logic              prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[MSB-1:0], d_i[i]};
                prev <= sh[MSB];
            end
        end
        assign lvl_o[i] = sh[MSB];
        assign chg_o[i] = sh[MSB] ^ prev;
    end

endmodule

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
    import tmr_slave_pkg::*;
(
    input  logic [3:0]          mode_i,
    input  logic [2:0]          tsel_i,
    input  logic                ext_clk2_en_i,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] chg_i,
    output ctl_t                ctl_o
);
    tsrc_e      src;
    logic       trg_lvl;
    logic       trg_rise;
    logic       ext_rise;
    logic       ext2;
    logic       base_tick;
    logic [1:0] q;

    always_comb begin
        src = decode_tsel(tsel_i);
        case (src)
            TS_IN1:  trg_lvl = lvl_i[PIN_IN1];
            TS_IN2:  trg_lvl = lvl_i[PIN_IN2];
            TS_EXT:  trg_lvl = lvl_i[PIN_EXT];
            default: trg_lvl = 1'b0;
        endcase
        case (src)
            TS_IN1:  trg_rise = lvl_i[PIN_IN1] & chg_i[PIN_IN1];
            TS_IN2:  trg_rise = lvl_i[PIN_IN2] & chg_i[PIN_IN2];
            TS_EXT:  trg_rise = lvl_i[PIN_EXT] & chg_i[PIN_EXT];
            default: trg_rise = 1'b0;
        endcase
        ext_rise = lvl_i[PIN_EXT] & chg_i[PIN_EXT];
        ext2 = ext_clk2_en_i | ((mode_i == SM_EXTCLK) && (src == TS_EXT));
        if (ext2)                     base_tick = ext_rise;
        else if (mode_i == SM_EXTCLK) base_tick = trg_rise;
        else                          base_tick = 1'b1;

        q = quad_eval(chg_i[PIN_IN1], chg_i[PIN_IN2], lvl_i[PIN_IN1], lvl_i[PIN_IN2],
                      (mode_i == SM_ENC_A) || (mode_i == SM_ENC_AB),
                      (mode_i == SM_ENC_B) || (mode_i == SM_ENC_AB));

        ctl_o = '0;
        case (mode_i)
            SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin
                ctl_o.tick = q[1];
                ctl_o.down = q[0];
                ctl_o.enc  = 1'b1;
            end
            SM_RESET: begin
                ctl_o.tick   = base_tick;
                ctl_o.reinit = trg_rise;
            end
            SM_GATED: ctl_o.tick = base_tick & trg_lvl;
            SM_TRIG: begin
                ctl_o.tick  = base_tick;
                ctl_o.start = trg_rise;
            end
            SM_COMBO: begin
                ctl_o.tick   = base_tick;
                ctl_o.reinit = trg_rise;
                ctl_o.start  = trg_rise;
            end
            default: ctl_o.tick = base_tick;
        endcase
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_slave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_i,
    input  logic             cen_set_i,
    input  logic             cen_clr_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             upd_o,
    output logic             cen_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             upd_q;
    logic             cen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
            upd_q <= 1'b0;
            cen_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (ctl_i.start || cen_set_i) cen_q <= 1'b1;
            else if (cen_clr_i)           cen_q <= 1'b0;
            if (!ctl_i.enc) dir_q <= 1'b0;
            if (ctl_i.reinit) begin
                cnt_q <= '0;
                upd_q <= 1'b1;
            end else if (ctl_i.tick && cen_q) begin
                if (ctl_i.enc) dir_q <= ctl_i.down;
                if (ctl_i.down) begin
                    if (cnt_q == '0) begin
                        cnt_q <= arr_i;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    if (cnt_q >= arr_i) begin
                        cnt_q <= '0;
                        upd_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign cnt_o      = cnt_q;
    assign dir_down_o = dir_q;
    assign upd_o      = upd_q;
    assign cen_o      = cen_q;

    // R6
    reinit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_i.reinit |=> (cnt_q == '0) && upd_q);

    // R3
    upd_value_chk: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (cnt_q == '0) || (cnt_q == $past(arr_i)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cen_q && !ctl_i.reinit) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
    import tmr_slave_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       mode_i,
    input  logic [2:0]       tsel_i,
    input  logic             ext_clk2_en_i,
    input  logic             ext_pol_i,
    input  logic             cen_set_i,
    input  logic             cen_clr_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic             in1_i,
    input  logic             in2_i,
    input  logic             ext_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_down_o,
    output logic             upd_o,
    output logic             cen_o
);
    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] chg;
    ctl_t                ctl;

    always_comb begin
        pins          = '0;
        pins[PIN_IN1] = in1_i;
        pins[PIN_IN2] = in2_i;
        pins[PIN_EXT] = ext_i ^ ext_pol_i;
    end

    tmr_insync #(.N(NUM_PINS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_i   (pins),
        .lvl_o (lvl),
        .chg_o (chg)
    );

    tmr_mode_dec u_dec (
        .mode_i        (mode_i),
        .tsel_i        (tsel_i),
        .ext_clk2_en_i (ext_clk2_en_i),
        .lvl_i         (lvl),
        .chg_i         (chg),
        .ctl_o         (ctl)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctl_i      (ctl),
        .cen_set_i  (cen_set_i),
        .cen_clr_i  (cen_clr_i),
        .arr_i      (arr_i),
        .cnt_o      (cnt_o),
        .dir_down_o (dir_down_o),
        .upd_o      (upd_o),
        .cen_o      (cen_o)
    );

    // R7
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SM_GATED && tsel_i == 3'b101 && !lvl[PIN_IN1]) |=> $stable(cnt_o));

    // R5
    enc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SM_ENC_B || mode_i == SM_ENC_A || mode_i == SM_ENC_AB) |=>
            (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1) ||
            (cnt_o == $past(cnt_o) - 1'b1) || (cnt_o == '0) || (cnt_o == $past(arr_i)));

    // R11
    no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SM_RESET && decode_tsel(tsel_i) == TS_NONE) |=> !upd_o || (cnt_o == '0));

endmodule

// File: tb/sim_tmr_slave_ctl.sv
module sim_tmr_slave_ctl;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   mode = 4'b0000;
    logic [2:0]   tsel = 3'b000;
    logic         ece = 1'b0;
    logic         pol = 1'b0;
    logic         cset = 1'b0;
    logic         cclr = 1'b0;
    logic [W-1:0] arr = 16'hFFFF;
    logic         in1 = 1'b0;
    logic         in2 = 1'b0;
    logic         ext = 1'b0;
    logic [W-1:0] cnt;
    logic         dir;
    logic         upd;
    logic         cen;

    int total = 0;
    int bad = 0;
    logic [W-1:0] v;

    always #2.5 clk = ~clk;

    tmr_slave_ctl #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .mode_i(mode), .tsel_i(tsel), .ext_clk2_en_i(ece),
        .ext_pol_i(pol), .cen_set_i(cset), .cen_clr_i(cclr), .arr_i(arr),
        .in1_i(in1), .in2_i(in2), .ext_i(ext),
        .cnt_o(cnt), .dir_down_o(dir), .upd_o(upd), .cen_o(cen)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // a pin change lands on the third rising edge; sample just after it
    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mode = 4'b0000; tsel = 3'b000; ece = 1'b0; pol = 1'b0;
        in1 = 1'b0; in2 = 1'b0; ext = 1'b0; arr = 16'hFFFF;
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_set();
        cset = 1'b1; @(negedge clk); cset = 1'b0;
    endtask

    task automatic pulse_clr();
        cclr = 1'b1; @(negedge clk); cclr = 1'b0;
    endtask

    task automatic quad(input logic a, input logic b);
        in1 = a; in2 = b; settle(); cyc(1);
    endtask

    task automatic pin_pulses(input int which, input int n);
        for (int k = 0; k < n; k++) begin
            if (which == 1) in1 = 1'b1; else if (which == 2) in2 = 1'b1; else ext = ~ext;
            cyc(4);
            if (which == 1) in1 = 1'b0; else if (which == 2) in2 = 1'b0; else ext = ~ext;
            cyc(4);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(cnt == 0, "R1 count", cnt, 0);
        chk(cen == 0 && upd == 0 && dir == 0, "R1 flags", {cen, upd, dir}, 0);
    endtask

    task automatic t_free_run();
        do_reset();
        cyc(3);
        chk(cnt == 0, "R2 no count with enable off", cnt, 0);
        pulse_set();
        v = cnt; cyc(5);
        chk(cnt == v + 5, "R2 internal clock", cnt, v + 5);
        mode = 4'b1010; tsel = 3'b101;
        v = cnt; in1 = 1'b1; settle();
        chk(cnt == v + 3, "R2 reserved mode ignores trigger", cnt, v + 3);
        in1 = 1'b0; mode = 4'b0000;
    endtask

    task automatic t_wrap_up();
        logic [W-1:0] p;
        do_reset();
        arr = 16'd3;
        pulse_set();
        for (int k = 0; k < 9; k++) begin
            p = cnt; @(negedge clk);
            if (p == 3) chk(cnt == 0 && upd, "R3 up wrap", cnt, 0);
            else        chk(cnt == p + 1 && !upd, "R3 up step", cnt, p + 1);
        end
    endtask

    task automatic t_encoder();
        do_reset();
        pulse_set();
        mode = 4'b0001;
        quad(1, 0); chk(cnt == 0, "R4 mode1 ignores in1 edge", cnt, 0);
        quad(1, 1); chk(cnt == 1, "R4 mode1 in2 edge", cnt, 1);
        quad(0, 1); quad(0, 0);
        chk(cnt == 2, "R4 mode1 full cycle", cnt, 2);
        mode = 4'b0010;
        quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        chk(cnt == 4, "R4 mode2 full cycle", cnt, 4);
        mode = 4'b0011;
        quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0);
        chk(cnt == 8 && dir == 0, "R5 forward both edges", cnt, 8);
        quad(0, 1);
        chk(cnt == 7 && dir == 1, "R5 reverse step direction", {dir, cnt}, {1'b1, 16'd7});
        quad(1, 1); quad(1, 0); quad(0, 0);
        chk(cnt == 4, "R5 reverse cycle", cnt, 4);
    endtask

    task automatic t_wrap_down();
        do_reset();
        arr = 16'd3;
        pulse_set();
        mode = 4'b0011;
        in2 = 1'b1; settle();
        chk(cnt == 3 && upd, "R3 down wrap", cnt, 3);
        cyc(1);
        chk(!upd, "R3 update single cycle", upd, 0);
    endtask

    task automatic t_reset_mode();
        do_reset();
        mode = 4'b0100; tsel = 3'b101;
        pulse_set();
        cyc(10);
        in1 = 1'b1; settle();
        chk(cnt == 0 && upd, "R6 reinit on rise", cnt, 0);
        cyc(1);
        chk(cnt == 1 && !upd, "R6 counts after reinit", cnt, 1);
        cyc(6);
        chk(cnt == 7, "R14 held level reinits once", cnt, 7);
        in1 = 1'b0; tsel = 3'b000; cyc(4);
        v = cnt; in1 = 1'b1; in2 = 1'b1; settle();
        chk(cnt == v + 3, "R11 reserved select no trigger", cnt, v + 3);
        in1 = 1'b0; in2 = 1'b0;
    endtask

    task automatic t_latency();
        do_reset();
        pulse_set();
        mode = 4'b0011;
        in1 = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(cnt == 0, "R14 no change before third edge", cnt, 0);
        @(negedge clk);
        chk(cnt == 1, "R14 change on third edge", cnt, 1);
    endtask

    task automatic t_gated();
        do_reset();
        mode = 4'b0101; tsel = 3'b110;
        pulse_set();
        cyc(6);
        chk(cnt == 0, "R7 low trigger holds", cnt, 0);
        in2 = 1'b1; cyc(4);
        v = cnt; cyc(5);
        chk(cnt == v + 5, "R7 counts while high", cnt, v + 5);
        in2 = 1'b0; cyc(4);
        v = cnt; cyc(6);
        chk(cnt == v && cnt != 0, "R7 held not cleared", cnt, v);
        in2 = 1'b0;
    endtask

    task automatic t_trigger();
        do_reset();
        pulse_set(); cyc(9); pulse_clr();
        mode = 4'b0110; tsel = 3'b101;
        v = cnt; cyc(4);
        chk(cnt == v && !cen, "R8 idle before trigger", cnt, v);
        in1 = 1'b1; settle();
        chk(cen == 1 && cnt == v, "R8 start without reset", cnt, v);
        cyc(4);
        chk(cnt == v + 4, "R8 running after start", cnt, v + 4);
        in1 = 1'b0;
    endtask

    task automatic t_extclk1();
        do_reset();
        mode = 4'b0111; tsel = 3'b110;
        pulse_set();
        pin_pulses(2, 5);
        chk(cnt == 5, "R9 one count per rise", cnt, 5);
        pin_pulses(1, 3);
        chk(cnt == 5, "R9 other input ignored", cnt, 5);
    endtask

    task automatic t_combined();
        do_reset();
        pulse_set(); cyc(7); pulse_clr();
        mode = 4'b1000; tsel = 3'b110;
        cyc(3);
        chk(cnt != 0 && !cen, "R10 stopped before trigger", cnt, 8);
        in2 = 1'b1; settle();
        chk(cnt == 0 && upd && cen, "R10 reinit and start", {cen, upd, cnt}, {2'b11, 16'd0});
        cyc(1);
        chk(cnt == 1, "R10 counting", cnt, 1);
        in2 = 1'b0;
    endtask

    task automatic t_ext2();
        do_reset();
        ece = 1'b1;
        pulse_set();
        cyc(4);
        chk(cnt == 0, "R12 no internal counting", cnt, 0);
        pin_pulses(3, 4);
        chk(cnt == 4, "R12 external rises", cnt, 4);
        ext = 1'b1; pol = 1'b1; cyc(4);
        ext = 1'b0; settle();
        chk(cnt == 5, "R12 inverted counts falling pin", cnt, 5);
        ext = 1'b1; cyc(4);
        chk(cnt == 5, "R12 inverted ignores rising pin", cnt, 5);
        ext = 1'b0; pol = 1'b0; cyc(4);
        mode = 4'b0111; tsel = 3'b101;
        pin_pulses(1, 3);
        chk(cnt == 5, "R12 trigger edges lose to external", cnt, 5);
        pin_pulses(3, 2);
        chk(cnt == 7, "R12 external wins in mode 0111", cnt, 7);
        mode = 4'b0101;
        pin_pulses(3, 2);
        chk(cnt == 7, "R13 gate low blocks external", cnt, 7);
        in1 = 1'b1; cyc(4);
        pin_pulses(3, 2);
        chk(cnt == 9, "R13 gate high passes external", cnt, 9);
        in1 = 1'b0; ece = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_free_run();
        t_wrap_up();
        t_encoder();
        t_wrap_down();
        t_reset_mode();
        t_latency();
        t_gated();
        t_trigger();
        t_extclk1();
        t_combined();
        t_ext2();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule